// File: doc/BRIEF.md
# Thread-Interleaved In-Order Integer Pipeline

This block is one five-stage integer pipeline (fetch, decode, execute, memory, writeback) shared by a set of hardware thread contexts. Each context acts as a separate simple single-threaded core. It has its own program counter and its own bank of sixteen registers. A thread counter picks a different context every cycle in strict rotation, and the thread count is at least the pipeline depth. Because of this, a context never has two instructions in flight at once. The pipeline therefore has no forwarding network, no hazard interlock and no branch flush.

An instruction memory shared by all contexts is written through a load port while the pipeline is idle. A `run` input lets instructions issue. Every context starts at word address 0 after reset, and an instruction that reads the thread number lets one program behave differently in each context. Loads and stores go out on a simple single-cycle data memory port. Every instruction that leaves writeback produces a retire record: thread, PC, destination, write flag and value. A checker can compare this record with a reference model for each thread.

Top module: `tip_core`

## Requirements
- R1: The issuing thread counter is 0 after reset and advances by one every clock cycle, wrapping from NTHREADS-1 to 0, whether or not `run` is high. An instruction fetched in cycle c belongs to the counter's thread and retires in cycle c+4. Back-to-back retires therefore carry consecutive thread numbers modulo NTHREADS.
- R2: Each thread has a private PC (word address, 0 after reset) and a private register bank (all zero after reset). A result written by one thread is never seen by another thread.
- R3: Instruction word encoding: bits 31:28 opcode, 27:24 rd, 23:20 rs1, 19:16 rs2, 15:0 imm. Opcodes: 0 ADD (rs1+rs2), 1 SUB (rs1-rs2), 2 AND, 3 OR, 4 XOR, 5 ADDI, 6 LW, 7 SW, 8 BEQ, 9 BNE, 10 TID, 11 JMP. Codes 12 to 15 do nothing.
- R4: ADDI writes rs1 plus imm sign-extended to XLEN. TID writes the issuing thread number, zero-extended.
- R5: LW and SW use the word address rs1 + sext(imm). SW drives `dmem_req` and `dmem_we` with rs2 on `dmem_wdata`. LW drives `dmem_req` with `dmem_we` low and writes the `dmem_rdata` value present in the same cycle to rd.
- R6: BEQ (rs1==rs2), BNE (rs1!=rs2) and JMP (always) set that thread's PC to PC + imm, with the low PC bits and modulo the memory depth. Otherwise the PC advances by one. No other thread's PC changes.
- R7: Register 0 of every bank reads as zero. A write aimed at it is dropped, and its retire record shows the write flag low.
- R8: While `run` is low, no instruction issues. Instructions already in flight complete, and all thread state is held, so execution continues correctly when `run` returns high.
- R9: Each retire record gives `ret_tid`, `ret_pc` and `ret_rd` from the instruction. `ret_data` is the result (or the loaded word) for register-writing opcodes and 0 for all others. `ret_wen` is high exactly when a register other than r0 is written.
- R10: Dependent instructions issued back to back by one thread read the results of their predecessors, with no stall cycles.
- R11: After reset and before `run` rises, `ret_valid` and `dmem_req` are low.
- R12: `imem_we` writes `imem_wdata` into instruction word `imem_addr`. PC arithmetic wraps modulo IMEM_DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Allows instruction issue |
| imem_we | input | 1 | Instruction memory write strobe |
| imem_addr | input | PC_W | Instruction word address for the load port |
| imem_wdata | input | 32 | Instruction word to write |
| dmem_req | output | 1 | Data memory access this cycle |
| dmem_we | output | 1 | Access is a store |
| dmem_addr | output | XLEN | Data word address |
| dmem_wdata | output | XLEN | Store data |
| dmem_rdata | input | XLEN | Load data, same cycle as the request |
| ret_valid | output | 1 | A retire record is present |
| ret_tid | output | TID_W | Retiring thread |
| ret_pc | output | PC_W | PC of the retiring instruction |
| ret_wen | output | 1 | A register was written |
| ret_rd | output | 4 | Destination field |
| ret_data | output | XLEN | Written or result value |

## Verification
The bench builds the block with NTHREADS=6 and IMEM_DEPTH=64. Six is not a power of two, so the counter must wrap explicitly. Six is also only one above the pipeline depth, so a thread's next fetch comes barely after its previous writeback and branch update. Depth 64 lets a backward jump from word 0 reach word 63 and wrap forward again. Every retire is compared with an independent per-thread reference model.

// File: rtl/tip_pkg.sv
package tip_pkg;
    localparam int INST_W = 32;
    localparam int REG_AW = 4;
    localparam int IMM_W  = 16;
    localparam int STAGES = 5;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_ADDI = 4'd5,
        OP_LW   = 4'd6,
        OP_SW   = 4'd7,
        OP_BEQ  = 4'd8,
        OP_BNE  = 4'd9,
        OP_TID  = 4'd10,
        OP_JMP  = 4'd11
    } op_e;
endpackage

// File: rtl/tip_imem.sv
module tip_imem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tip_regfile.sv
module tip_regfile import tip_pkg::*; #(
    parameter int NTHREADS = 8,
    parameter int XLEN     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(NTHREADS)-1:0]   rd_tid,
    input  logic [REG_AW-1:0]             ra_idx,
    input  logic [REG_AW-1:0]             rb_idx,
    output logic [XLEN-1:0]               ra_data,
    output logic [XLEN-1:0]               rb_data,
    input  logic                          we,
    input  logic [$clog2(NTHREADS)-1:0]   wr_tid,
    input  logic [REG_AW-1:0]             wr_idx,
    input  logic [XLEN-1:0]               wr_data
);
    localparam int NREGS = 1 << REG_AW;

    logic [NTHREADS-1:0][NREGS-1:0][XLEN-1:0] bank_q, bank_d;

    always_comb begin
        bank_d = bank_q;
        if (we && wr_idx != '0) bank_d[wr_tid][wr_idx] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign ra_data = bank_q[rd_tid][ra_idx];
    assign rb_data = bank_q[rd_tid][rb_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_idx != '0) |=> bank_q[$past(wr_tid)][$past(wr_idx)] == $past(wr_data)); // R2

    AST_ZERO_REG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_idx == '0) |=> bank_q[$past(wr_tid)][0] == '0); // R7
endmodule

// File: rtl/tip_alu.sv
module tip_alu import tip_pkg::*; #(
    parameter int XLEN  = 32,
    parameter int PC_W  = 6,
    parameter int TID_W = 3
) (
    input  op_e              op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [IMM_W-1:0] imm,
    input  logic [PC_W-1:0]  pc,
    input  logic [TID_W-1:0] tid,
    output logic [XLEN-1:0]  result,
    output logic             writes,
    output logic             is_load,
    output logic             is_store,
    output logic [XLEN-1:0]  addr,
    output logic             taken,
    output logic [PC_W-1:0]  target
);
    logic [XLEN-1:0] simm;

    assign simm   = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign addr   = a + simm;
    assign target = pc + imm[PC_W-1:0];

    always_comb begin
        result   = '0;
        writes   = 1'b0;
        is_load  = 1'b0;
        is_store = 1'b0;
        taken    = 1'b0;
        unique case (op)
            OP_ADD:  begin result = a + b;            writes = 1'b1; end
            OP_SUB:  begin result = a - b;            writes = 1'b1; end
            OP_AND:  begin result = a & b;            writes = 1'b1; end
            OP_OR:   begin result = a | b;            writes = 1'b1; end
            OP_XOR:  begin result = a ^ b;            writes = 1'b1; end
            OP_ADDI: begin result = a + simm;         writes = 1'b1; end
            OP_TID:  begin result = XLEN'(tid);       writes = 1'b1; end
            OP_LW:   begin is_load = 1'b1;            writes = 1'b1; end
            OP_SW:   is_store = 1'b1;
            OP_BEQ:  taken = (a == b);
            OP_BNE:  taken = (a != b);
            OP_JMP:  taken = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tip_core.sv
module tip_core import tip_pkg::*; #(
    parameter int NTHREADS   = 8,
    parameter int XLEN       = 32,
    parameter int IMEM_DEPTH = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run,
    input  logic                          imem_we,
    input  logic [$clog2(IMEM_DEPTH)-1:0] imem_addr,
    input  logic [INST_W-1:0]             imem_wdata,
    output logic                          dmem_req,
    output logic                          dmem_we,
    output logic [XLEN-1:0]               dmem_addr,
    output logic [XLEN-1:0]               dmem_wdata,
    input  logic [XLEN-1:0]               dmem_rdata,
    output logic                          ret_valid,
    output logic [$clog2(NTHREADS)-1:0]   ret_tid,
    output logic [$clog2(IMEM_DEPTH)-1:0] ret_pc,
    output logic                          ret_wen,
    output logic [REG_AW-1:0]             ret_rd,
    output logic [XLEN-1:0]               ret_data
);
    localparam int TID_W   = $clog2(NTHREADS);
    localparam int PC_W    = $clog2(IMEM_DEPTH);
    localparam int WB_LAG  = STAGES - 1;

    initial assert (NTHREADS >= STAGES);
    initial assert ((1 << PC_W) == IMEM_DEPTH);

    typedef struct packed {
        logic              v;
        logic [TID_W-1:0]  tid;
        logic [PC_W-1:0]   pc;
        logic [INST_W-1:0] inst;
    } fd_t;

    typedef struct packed {
        logic              v;
        logic [TID_W-1:0]  tid;
        logic [PC_W-1:0]   pc;
        op_e               op;
        logic [REG_AW-1:0] rd;
        logic [IMM_W-1:0]  imm;
        logic [XLEN-1:0]   a;
        logic [XLEN-1:0]   b;
    } dx_t;

    typedef struct packed {
        logic              v;
        logic [TID_W-1:0]  tid;
        logic [PC_W-1:0]   pc;
        logic [REG_AW-1:0] rd;
        logic              wen;
        logic              ld;
        logic              st;
        logic [XLEN-1:0]   addr;
        logic [XLEN-1:0]   sdata;
        logic [XLEN-1:0]   res;
    } xm_t;

    typedef struct packed {
        logic              v;
        logic [TID_W-1:0]  tid;
        logic [PC_W-1:0]   pc;
        logic [REG_AW-1:0] rd;
        logic              wen;
        logic [XLEN-1:0]   data;
    } mw_t;

    typedef struct packed {
        logic [TID_W-1:0]                 tid;
        logic [NTHREADS-1:0][PC_W-1:0]    pc;
        fd_t                              fd;
        dx_t                              dx;
        xm_t                              xm;
        mw_t                              mw;
    } state_t;

    state_t s_q, s_d;

    logic [INST_W-1:0] fetch_word;
    logic [XLEN-1:0]   rs1_val, rs2_val;
    logic [XLEN-1:0]   alu_res, alu_addr;
    logic              alu_writes, alu_ld, alu_st, alu_taken;
    logic [PC_W-1:0]   alu_target;

    tip_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(INST_W)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_addr),
        .wdata (imem_wdata),
        .raddr (s_q.pc[s_q.tid]),
        .rdata (fetch_word)
    );

    tip_regfile #(.NTHREADS(NTHREADS), .XLEN(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_tid  (s_q.fd.tid),
        .ra_idx  (s_q.fd.inst[23:20]),
        .rb_idx  (s_q.fd.inst[19:16]),
        .ra_data (rs1_val),
        .rb_data (rs2_val),
        .we      (s_q.mw.v && s_q.mw.wen),
        .wr_tid  (s_q.mw.tid),
        .wr_idx  (s_q.mw.rd),
        .wr_data (s_q.mw.data)
    );

    tip_alu #(.XLEN(XLEN), .PC_W(PC_W), .TID_W(TID_W)) u_alu (
        .op       (s_q.dx.op),
        .a        (s_q.dx.a),
        .b        (s_q.dx.b),
        .imm      (s_q.dx.imm),
        .pc       (s_q.dx.pc),
        .tid      (s_q.dx.tid),
        .result   (alu_res),
        .writes   (alu_writes),
        .is_load  (alu_ld),
        .is_store (alu_st),
        .addr     (alu_addr),
        .taken    (alu_taken),
        .target   (alu_target)
    );

    always_comb begin
        s_d = s_q;
        // thread rotation
        s_d.tid = (s_q.tid == TID_W'(NTHREADS - 1)) ? '0 : s_q.tid + 1'b1;
        // fetch
        s_d.fd.v    = run;
        s_d.fd.tid  = s_q.tid;
        s_d.fd.pc   = s_q.pc[s_q.tid];
        s_d.fd.inst = fetch_word;
        if (run) s_d.pc[s_q.tid] = s_q.pc[s_q.tid] + 1'b1;
        // decode and register read
        s_d.dx.v   = s_q.fd.v;
        s_d.dx.tid = s_q.fd.tid;
        s_d.dx.pc  = s_q.fd.pc;
        s_d.dx.op  = op_e'(s_q.fd.inst[31:28]);
        s_d.dx.rd  = s_q.fd.inst[27:24];
        s_d.dx.imm = s_q.fd.inst[15:0];
        s_d.dx.a   = rs1_val;
        s_d.dx.b   = rs2_val;
        // execute; a taken branch rewrites only its own thread's PC
        s_d.xm.v     = s_q.dx.v;
        s_d.xm.tid   = s_q.dx.tid;
        s_d.xm.pc    = s_q.dx.pc;
        s_d.xm.rd    = s_q.dx.rd;
        s_d.xm.wen   = alu_writes && (s_q.dx.rd != '0);
        s_d.xm.ld    = alu_ld;
        s_d.xm.st    = alu_st;
        s_d.xm.addr  = alu_addr;
        s_d.xm.sdata = s_q.dx.b;
        s_d.xm.res   = alu_res;
        if (s_q.dx.v && alu_taken) s_d.pc[s_q.dx.tid] = alu_target;
        // memory
        s_d.mw.v    = s_q.xm.v;
        s_d.mw.tid  = s_q.xm.tid;
        s_d.mw.pc   = s_q.xm.pc;
        s_d.mw.rd   = s_q.xm.rd;
        s_d.mw.wen  = s_q.xm.wen;
        s_d.mw.data = s_q.xm.ld ? dmem_rdata : s_q.xm.res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dmem_req   = s_q.xm.v && (s_q.xm.ld || s_q.xm.st);
    assign dmem_we    = s_q.xm.v && s_q.xm.st;
    assign dmem_addr  = s_q.xm.addr;
    assign dmem_wdata = s_q.xm.sdata;

    assign ret_valid = s_q.mw.v;
    assign ret_tid   = s_q.mw.tid;
    assign ret_pc    = s_q.mw.pc;
    assign ret_wen   = s_q.mw.wen;
    assign ret_rd    = s_q.mw.rd;
    assign ret_data  = s_q.mw.data;

    AST_RETIRE_TID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ((int'(ret_tid) + WB_LAG) % NTHREADS) == int'(s_q.tid)); // R1

    AST_DX_XM_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.dx.v && s_q.xm.v) |-> s_q.dx.tid != s_q.xm.tid); // R10

    AST_XM_MW_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.xm.v && s_q.mw.v) |-> s_q.xm.tid != s_q.mw.tid); // R10

    AST_RETIRE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $past(run, 4)); // R8

    AST_R0_NO_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_rd == '0) |-> !ret_wen); // R7

    AST_STORE_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> dmem_req); // R5
endmodule

// File: tb/tip_core_tb.sv
module tip_core_tb;
    localparam int NT   = 6;
    localparam int DEP  = 64;
    localparam int PW   = $clog2(DEP);
    localparam int TW   = $clog2(NT);
    localparam int MEMW = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic imem_we = 1'b0;
    logic [PW-1:0] imem_addr = '0;
    logic [31:0] imem_wdata = '0;
    logic dmem_req, dmem_we;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic ret_valid, ret_wen;
    logic [TW-1:0] ret_tid;
    logic [PW-1:0] ret_pc;
    logic [3:0] ret_rd;
    logic [31:0] ret_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int ret_count = 0;
    bit saw_pc63 = 0;
    bit prev_v = 0;
    int prev_tid = 0;

    logic [31:0] dmem [MEMW];
    logic [31:0] rmem [MEMW];
    logic [31:0] bimem [DEP];
    logic [31:0] rreg [NT][16];
    logic [PW-1:0] rpc [NT];

    always #10 clk = ~clk;

    tip_core #(.NTHREADS(NT), .XLEN(32), .IMEM_DEPTH(DEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .ret_valid(ret_valid), .ret_tid(ret_tid), .ret_pc(ret_pc),
        .ret_wen(ret_wen), .ret_rd(ret_rd), .ret_data(ret_data)
    );

    assign dmem_rdata = dmem[dmem_addr[9:0]];

    always @(posedge clk) begin
        if (dmem_req && dmem_we) dmem[dmem_addr[9:0]] <= dmem_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int op, input int rd, input int s1,
                                        input int s2, input int imm);
        logic [31:0] w;
        w = {op[3:0], rd[3:0], s1[3:0], s2[3:0], imm[15:0]};
        return w;
    endfunction

    // reference model step for one retiring instruction of thread t (R3..R7, R9)
    task automatic ref_step(input int t);
        logic [31:0] ins, a, b, simm, res;
        logic [3:0] op, rd;
        bit wr, tk;
        logic [PW-1:0] npc;
        ins  = bimem[rpc[t]];
        op   = ins[31:28];
        rd   = ins[27:24];
        a    = rreg[t][ins[23:20]];
        b    = rreg[t][ins[19:16]];
        simm = {{16{ins[15]}}, ins[15:0]};
        res  = '0; wr = 0; tk = 0;
        case (op)
            4'd0:  begin res = a + b; wr = 1; end
            4'd1:  begin res = a - b; wr = 1; end
            4'd2:  begin res = a & b; wr = 1; end
            4'd3:  begin res = a | b; wr = 1; end
            4'd4:  begin res = a ^ b; wr = 1; end
            4'd5:  begin res = a + simm; wr = 1; end
            4'd6:  begin res = rmem[(a + simm) & (MEMW - 1)]; wr = 1; end
            4'd7:  rmem[(a + simm) & (MEMW - 1)] = b;
            4'd8:  tk = (a == b);
            4'd9:  tk = (a != b);
            4'd10: begin res = t; wr = 1; end
            4'd11: tk = 1;
            default: ;
        endcase
        npc = tk ? rpc[t] + ins[PW-1:0] : rpc[t] + 1'b1;
        chk("R6 retire pc", 32'(ret_pc), 32'(rpc[t]));
        chk("R9 retire rd", 32'(ret_rd), 32'(rd));
        chk("R7 retire wen", 32'(ret_wen), 32'(wr && rd != 0));
        chk("R9 retire data", ret_data, res);
        if (wr && rd != 0) rreg[t][rd] = res;
        rpc[t] = npc;
    endtask

    // retire monitor: rotation (R1) and per-thread reference compare (R2, R10)
    always @(negedge clk) begin
        cyc++;
        if (rst_n && ret_valid) begin
            ret_count++;
            if (ret_pc == PW'(63)) saw_pc63 = 1;
            if (prev_v) chk("R1 tid rotation", 32'(ret_tid), 32'((prev_tid + 1) % NT));
            ref_step(int'(ret_tid));
        end
        prev_v   = rst_n && ret_valid;
        prev_tid = int'(ret_tid);
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        run = 1'b0;
        for (int i = 0; i < MEMW; i++) begin dmem[i] = '0; rmem[i] = '0; end
        for (int t = 0; t < NT; t++) begin
            rpc[t] = '0;
            for (int r = 0; r < 16; r++) rreg[t][r] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 no retire after reset", 32'(ret_valid), 0);
        chk("R11 no dmem req after reset", 32'(dmem_req), 0);
    endtask

    task automatic load_word(input int addr, input logic [31:0] w);
        imem_we = 1'b1;
        imem_addr = PW'(addr);
        imem_wdata = w;
        bimem[addr] = w;
        @(negedge clk);
        imem_we = 1'b0;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < DEP; i++) load_word(i, 32'hF000_0000);
    endtask

    task automatic run_for(input int n);
        run = 1'b1;
        repeat (n) @(negedge clk);
        run = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic prog_alu();
        clear_prog();
        load_word(0,  enc(10, 1, 0, 0, 0));
        load_word(1,  enc(5, 2, 1, 0, 5));
        load_word(2,  enc(0, 3, 2, 2, 0));
        load_word(3,  enc(1, 4, 3, 1, 0));
        load_word(4,  enc(4, 5, 4, 2, 0));
        load_word(5,  enc(3, 6, 5, 1, 0));
        load_word(6,  enc(2, 7, 6, 3, 0));
        load_word(7,  enc(5, 0, 0, 0, 7));
        load_word(8,  enc(0, 8, 0, 7, 0));
        load_word(9,  enc(5, 9, 1, 0, -3));
        load_word(10, enc(0, 10, 1, 1, 0));
        load_word(11, enc(0, 10, 10, 10, 0));
        load_word(12, enc(7, 0, 10, 8, 256));
        load_word(13, enc(7, 0, 10, 9, 257));
        load_word(14, enc(11, 0, 0, 0, 0));
    endtask

    task automatic check_alu_results(input string tag);
        for (int t = 0; t < NT; t++) begin
            logic [31:0] r2, r3, r4, r5, r6, r7;
            r2 = t + 5; r3 = 2 * t + 10; r4 = t + 10;
            r5 = r4 ^ r2; r6 = r5 | t; r7 = r6 & r3;
            chk({tag, " R2 R4 R10 chain result"}, dmem[256 + 4 * t], r7);
            chk({tag, " R4 negative imm"}, dmem[257 + 4 * t], 32'(t - 3));
        end
    endtask

    task automatic test_alu();
        do_reset();
        prog_alu();
        run_for(200);
        check_alu_results("alu");
    endtask

    task automatic test_branch();
        do_reset();
        clear_prog();
        load_word(0,  enc(10, 4, 0, 0, 0));
        load_word(1,  enc(5, 1, 0, 0, 3));
        load_word(2,  enc(5, 2, 2, 0, 1));
        load_word(3,  enc(5, 1, 1, 0, -1));
        load_word(4,  enc(9, 0, 1, 0, -2));
        load_word(5,  enc(8, 0, 0, 0, 2));
        load_word(6,  enc(5, 3, 0, 0, 99));
        load_word(7,  enc(0, 5, 4, 4, 0));
        load_word(8,  enc(7, 0, 5, 2, 512));
        load_word(9,  enc(7, 0, 5, 3, 513));
        load_word(10, enc(11, 0, 0, 0, 0));
        run_for(250);
        for (int t = 0; t < NT; t++) begin
            chk("R6 loop count", dmem[512 + 2 * t], 3);
            chk("R6 skipped instr", dmem[513 + 2 * t], 0);
        end
    endtask

    task automatic test_mem();
        do_reset();
        clear_prog();
        load_word(0, enc(10, 1, 0, 0, 0));
        load_word(1, enc(5, 2, 1, 0, 100));
        load_word(2, enc(7, 0, 1, 2, 768));
        load_word(3, enc(6, 3, 1, 0, 768));
        load_word(4, enc(5, 3, 3, 0, 1));
        load_word(5, enc(7, 0, 1, 3, 776));
        load_word(6, enc(6, 0, 1, 0, 768));
        load_word(7, enc(11, 0, 0, 0, 0));
        run_for(150);
        for (int t = 0; t < NT; t++) begin
            chk("R5 store", dmem[768 + t], 32'(t + 100));
            chk("R5 load then add", dmem[776 + t], 32'(t + 101));
        end
    endtask

    task automatic test_pause();
        int c0;
        do_reset();
        prog_alu();
        run = 1'b1;
        repeat (30) @(negedge clk);
        run = 1'b0;
        repeat (5) @(negedge clk);
        c0 = ret_count;
        repeat (15) @(negedge clk);
        chk("R8 no retire while paused", 32'(ret_count), 32'(c0));
        run_for(200);
        check_alu_results("pause");
    endtask

    task automatic test_wrap();
        do_reset();
        clear_prog();
        load_word(0,  enc(11, 0, 0, 0, -1));
        load_word(63, enc(5, 1, 1, 0, 1));
        saw_pc63 = 0;
        run_for(120);
        chk("R12 pc wrapped to 63", 32'(saw_pc63), 1);
    endtask

    initial begin
        test_alu();
        test_branch();
        test_mem();
        test_pause();
        test_wrap();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule